// File: doc/BRIEF.md
# Prioritized Interrupt Controller (96 Sources)

This block gathers 96 level-sensitive interrupt sources and presents up to two interrupt requests to a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Sources are grouped into three banks of 32. Source n is bit (n mod 32) of bank (n / 32). Each source can be masked, forced pending from software, given a 6-bit priority, and routed to either request.

Among the eligible sources on each path, the controller picks a winner and latches its number and priority. Software reads these through sorted-source registers. The winner stays frozen until software writes an acknowledge, and a fresh arbitration follows one clock later. A global 8-bit threshold can hold back low-urgency sources. A soft reset bit returns the whole block to its power-up state.

Software reaches the block through a flat 32-bit register port. The port takes a byte address and a write strobe, and read data is combinational from the address.

Top module: `prio_intc`

Register offsets (byte addresses): 0x10 system config (bit 1 soft reset), 0x14 system status (bit 0 reset done), 0x40 sorted IRQ, 0x44 sorted FIQ, 0x48 control, 0x60 IRQ priority, 0x64 FIQ priority, 0x68 threshold. Bank k starts at 0x80 + 0x20·k and holds eight words in this order: raw, mask, mask-clear, mask-set, soft-set, soft-clear, pending IRQ, pending FIQ. The line register of source n is at 0x100 + 4·n.

## Requirements
- R1: After reset, every mask bit reads 1, every line register reads 0, the threshold reads 0xFF, both sorted registers read 0x80, both priority registers read 0, system status bit 0 reads 1, and `irq_o`/`fiq_o` are low.
- R2: Writing 1s to a bank's mask-clear word clears those mask bits, and writing 1s to its mask-set word sets them. Zero bits leave the mask unchanged. The mask word reads back the mask, where 1 means masked. A masked source never raises `irq_o` or `fiq_o`.
- R3: The raw word reads (input OR soft-pending) for its 32 sources, ignoring masks. The pending-IRQ word reads raw AND NOT mask for sources routed to IRQ. The pending-FIQ word does the same for sources routed to FIQ.
- R4: Writing 1s to the soft-set word makes those sources pending, and the word reads back the soft-pending bits. Writing 1s to the soft-clear word removes them. The soft-clear word reads 0.
- R5: Line register bits 7:2 hold the priority and bit 0 holds the route (1 = FIQ, 0 = IRQ). Other bits read 0.
- R6: Among eligible IRQ sources, the lowest priority value wins, and ties go to the lowest source number. The sorted-IRQ word reads the winner in bits 6:0 with bit 7 = 0. With no winner latched it reads 0x80.
- R7: FIQ-routed sources are arbitrated separately. The FIQ winner drives `fiq_o` and the sorted-FIQ word, and it never appears on the IRQ path.
- R8: Once latched, a winner's number and priority (IRQ priority word, FIQ priority word) hold, even if a more urgent source arrives, until acknowledged.
- R9: Writing 1 to control bit 0 releases both latched winners on that clock edge. A pending winner is latched on the next edge.
- R10: With the threshold not equal to 0xFF, a source is eligible only if its priority value is strictly below the threshold.
- R11: Writing 1 to system config bit 1 makes system status bit 0 read 0 for one cycle. On the following edge the block returns to its R1 state and status reads 1 again.
- R12: `irq_o` and `fiq_o` are high exactly while a winner is latched on their path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted latched winner shows up in the sorted word and the priority word on the very next read. It stays visible there until acknowledge, because nothing else may change it. A lost mask or soft-pending bit shows in the raw or pending words at once. It also shows one edge later as a request that fires or stays silent against expectation. A wrong acknowledge or arbitration timing is caught by sampling the request line in the cycle right after the acknowledge and again one edge later.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC = 96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic [9:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int NBANK = NSRC / 32;

  logic [NSRC-1:0] mask_q, swp_q, route_q;
  logic [5:0]      prio_q [NSRC];
  logic [7:0]      thr_q;
  logic            srst_q;
  logic            irq_act, fiq_act;
  logic [6:0]      irq_idx, fiq_idx;
  logic [5:0]      irq_prio, fiq_prio;

  logic [NSRC-1:0] raw, elig;
  logic            irq_found, fiq_found;
  logic [6:0]      irq_win, fiq_win;
  logic [5:0]      irq_best, fiq_best;

  wire       in_bank = addr[9:7] == 3'b001;
  wire [1:0] bsel    = addr[6:5];
  wire [2:0] rsel    = addr[4:2];
  wire [7:0] lidx    = addr[9:2] - 8'd64;
  wire       in_line = (addr[9:8] != 2'b00) && (lidx < 8'(NSRC));
  wire       ack     = wr_en && addr == 10'h048 && wdata[0];
  logic      unused_bits;
  assign unused_bits = ^addr[1:0];

  assign raw   = src_i | swp_q;
  assign irq_o = irq_act;
  assign fiq_o = fiq_act;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      elig[i] = raw[i] && !mask_q[i] && (thr_q == 8'hFF || {2'b00, prio_q[i]} < thr_q);
  end

  always_comb begin
    irq_found = 1'b0; irq_win = '0; irq_best = '0;
    fiq_found = 1'b0; fiq_win = '0; fiq_best = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && !route_q[i] && (!irq_found || prio_q[i] <= irq_best)) begin
        irq_found = 1'b1; irq_win = 7'(i); irq_best = prio_q[i];
      end
      if (elig[i] && route_q[i] && (!fiq_found || prio_q[i] <= fiq_best)) begin
        fiq_found = 1'b1; fiq_win = 7'(i); fiq_best = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1; swp_q <= '0; route_q <= '0; thr_q <= 8'hFF; srst_q <= 1'b0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      irq_act <= 1'b0; fiq_act <= 1'b0;
      irq_idx <= '0; fiq_idx <= '0; irq_prio <= '0; fiq_prio <= '0;
    end else if (srst_q) begin
      mask_q <= '1; swp_q <= '0; route_q <= '0; thr_q <= 8'hFF; srst_q <= 1'b0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      irq_act <= 1'b0; fiq_act <= 1'b0;
      irq_idx <= '0; fiq_idx <= '0; irq_prio <= '0; fiq_prio <= '0;
    end else begin
      if (wr_en && addr == 10'h010 && wdata[1]) srst_q <= 1'b1;
      if (wr_en && addr == 10'h068) thr_q <= wdata[7:0];
      for (int b = 0; b < NBANK; b++) begin
        if (wr_en && in_bank && bsel == 2'(b)) begin
          case (rsel)
            3'd2: mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] & ~wdata;
            3'd3: mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] | wdata;
            3'd4: swp_q[b*32 +: 32]  <= swp_q[b*32 +: 32] | wdata;
            3'd5: swp_q[b*32 +: 32]  <= swp_q[b*32 +: 32] & ~wdata;
            default: ;
          endcase
        end
      end
      if (wr_en && in_line) begin
        prio_q[lidx[6:0]]  <= wdata[7:2];
        route_q[lidx[6:0]] <= wdata[0];
      end
      if (ack) begin
        irq_act <= 1'b0;
        fiq_act <= 1'b0;
      end else begin
        if (!irq_act && irq_found) begin
          irq_act <= 1'b1; irq_idx <= irq_win; irq_prio <= irq_best;
        end
        if (!fiq_act && fiq_found) begin
          fiq_act <= 1'b1; fiq_idx <= fiq_win; fiq_prio <= fiq_best;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (in_bank && bsel < 2'(NBANK)) begin
      case (rsel)
        3'd0: rdata = raw[bsel*32 +: 32];
        3'd1: rdata = mask_q[bsel*32 +: 32];
        3'd4: rdata = swp_q[bsel*32 +: 32];
        3'd6: rdata = raw[bsel*32 +: 32] & ~mask_q[bsel*32 +: 32] & ~route_q[bsel*32 +: 32];
        3'd7: rdata = raw[bsel*32 +: 32] & ~mask_q[bsel*32 +: 32] & route_q[bsel*32 +: 32];
        default: rdata = '0;
      endcase
    end else if (in_line) begin
      rdata = {24'd0, prio_q[lidx[6:0]], 1'b0, route_q[lidx[6:0]]};
    end else begin
      case (addr)
        10'h014: rdata = {31'd0, !srst_q};
        10'h040: rdata = {24'd0, !irq_act, irq_act ? irq_idx : 7'd0};
        10'h044: rdata = {24'd0, !fiq_act, fiq_act ? fiq_idx : 7'd0};
        10'h060: rdata = {26'd0, irq_act ? irq_prio : 6'd0};
        10'h064: rdata = {26'd0, fiq_act ? fiq_prio : 6'd0};
        10'h068: rdata = {24'd0, thr_q};
        default: rdata = '0;
      endcase
    end
  end

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_o && !fiq_o);

  // R8
  winner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_act && !ack && !srst_q |=> irq_act && $stable(irq_idx) && $stable(irq_prio));

  // R10
  thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_act) && $past(thr_q) != 8'hFF |-> {2'b00, irq_prio} < $past(thr_q));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !irq_o && !fiq_o && mask_q == '1 && thr_q == 8'hFF);

  // R2
  masked_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) && !irq_act |=> !irq_act);
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;
  int checks = 0;
  int fails = 0;

  prio_intc i_prio_intc (.clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  always #10 clk = ~clk;

  function automatic logic [9:0] bk(int k, int r);
    return 10'(32'h80 + 32'h20 * k + 4 * r);
  endfunction
  function automatic logic [9:0] ln(int n);
    return 10'(32'h100 + 4 * n);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    src_i = '0; wr_en = 1'b0;
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    do_reset;
    rd(bk(2, 1), d); chk("R1 mask", d, 32'hFFFFFFFF);
    rd(10'h068, d); chk("R1 threshold", d, 32'hFF);
    rd(10'h040, d); chk("R1 sorted irq", d, 32'h80);
    rd(10'h044, d); chk("R1 sorted fiq", d, 32'h80);
    rd(ln(95), d); chk("R1 line", d, 0);
    rd(10'h014, d); chk("R1 status", d, 1);
    chk("R1 outputs", {30'd0, irq_o, fiq_o}, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    do_reset;
    wr(bk(1, 2), 32'h00000F00);
    rd(bk(1, 1), d); chk("R2 mask clear", d, 32'hFFFFF0FF);
    wr(bk(1, 3), 32'h00000100);
    rd(bk(1, 1), d); chk("R2 mask set", d, 32'hFFFFF1FF);
    src_i[3] = 1'b1; cyc(3);
    chk("R2 masked source ignored", {31'd0, irq_o}, 0);
    rd(10'h040, d); chk("R2 masked sorted", d, 32'h80);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    do_reset;
    wr(ln(70), 32'h1);
    wr(bk(1, 2), 32'h100);
    wr(bk(2, 2), 32'h40);
    src_i[40] = 1'b1; src_i[70] = 1'b1; src_i[41] = 1'b1;
    rd(bk(1, 0), d); chk("R3 raw bank1", d, 32'h300);
    rd(bk(1, 6), d); chk("R3 pend irq bank1", d, 32'h100);
    rd(bk(2, 7), d); chk("R3 pend fiq bank2", d, 32'h40);
    rd(bk(2, 6), d); chk("R3 pend irq bank2", d, 0);
  endtask

  task automatic t_soft;
    logic [31:0] d;
    do_reset;
    wr(bk(0, 4), 32'h11);
    rd(bk(0, 4), d); chk("R4 soft set", d, 32'h11);
    rd(bk(0, 0), d); chk("R4 raw", d, 32'h11);
    wr(bk(0, 5), 32'h01);
    rd(bk(0, 4), d); chk("R4 soft clear", d, 32'h10);
    rd(bk(0, 5), d); chk("R4 clear reads 0", d, 0);
  endtask

  task automatic t_line;
    logic [31:0] d;
    do_reset;
    wr(ln(33), 32'hFFFFFFFF);
    rd(ln(33), d); chk("R5 line fields", d, 32'hFD);
    wr(ln(33), 32'h0C);
    rd(ln(33), d); chk("R5 line prio", d, 32'h0C);
  endtask

  task automatic t_arb_ack;
    logic [31:0] d;
    do_reset;
    wr(ln(10), 5 << 2); wr(ln(20), 3 << 2); wr(ln(30), 3 << 2);
    wr(bk(0, 2), (1 << 10) | (1 << 20) | (1 << 30));
    wr(bk(0, 4), (1 << 10) | (1 << 20) | (1 << 30));
    cyc(1);
    chk("R12 irq high", {31'd0, irq_o}, 1);
    rd(10'h040, d); chk("R6 tie lowest number", d, 20);
    rd(10'h060, d); chk("R8 irq prio", d, 3);
    wr(ln(50), 1 << 2); wr(bk(1, 2), 1 << 18); wr(bk(1, 4), 1 << 18);
    cyc(2);
    rd(10'h040, d); chk("R8 frozen", d, 20);
    wr(10'h048, 1);
    chk("R9 released", {31'd0, irq_o}, 0);
    rd(10'h040, d); chk("R9 idle sorted", d, 32'h80);
    cyc(1);
    rd(10'h040, d); chk("R9 new winner", d, 50);
    rd(10'h060, d); chk("R6 prio 1", d, 1);
    wr(bk(1, 5), 1 << 18); wr(10'h048, 1); cyc(1);
    rd(10'h040, d); chk("R6 back to 20", d, 20);
  endtask

  task automatic t_fiq;
    logic [31:0] d;
    do_reset;
    wr(ln(70), (2 << 2) | 1); wr(ln(71), 9 << 2);
    wr(bk(2, 2), 32'hC0);
    src_i[70] = 1'b1; src_i[71] = 1'b1; cyc(2);
    chk("R7 fiq high", {31'd0, fiq_o}, 1);
    rd(10'h044, d); chk("R7 sorted fiq", d, 70);
    rd(10'h064, d); chk("R7 fiq prio", d, 2);
    rd(10'h040, d); chk("R7 irq path", d, 71);
  endtask

  task automatic t_thr;
    logic [31:0] d;
    do_reset;
    wr(ln(5), 4 << 2); wr(10'h068, 4); wr(bk(0, 2), 1 << 5);
    src_i[5] = 1'b1; cyc(3);
    chk("R10 blocked", {31'd0, irq_o}, 0);
    wr(10'h068, 5); cyc(1);
    chk("R10 passed", {31'd0, irq_o}, 1);
    rd(10'h040, d); chk("R10 sorted", d, 5);
  endtask

  task automatic t_srst;
    logic [31:0] d;
    do_reset;
    wr(bk(0, 2), 1); wr(bk(0, 4), 1); wr(10'h068, 8'h20); cyc(1);
    chk("R11 pre irq", {31'd0, irq_o}, 1);
    wr(10'h010, 2);
    rd(10'h014, d); chk("R11 status busy", d, 0);
    cyc(1);
    rd(10'h014, d); chk("R11 status done", d, 1);
    chk("R11 irq low", {31'd0, irq_o}, 0);
    rd(bk(0, 1), d); chk("R11 mask", d, 32'hFFFFFFFF);
    rd(bk(0, 4), d); chk("R11 soft", d, 0);
    rd(10'h068, d); chk("R11 thr", d, 32'hFF);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset; t_mask; t_pending; t_soft; t_line;
    t_arb_ack; t_fiq; t_thr; t_srst;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule